// File: doc/BRIEF.md
# Hot-Plug Slot Power and Reset Sequencer

This block sequences power and reset for a single downstream hot-plug slot. Software sets or clears a power request bit. The block drives a slot power enable and an active-low slot reset. The order of the two outputs differs between power-up and power-down. On power-up, power is enabled first. Reset stays asserted until the power-good input has been good for a programmed number of timebase ticks. On power-down, reset is asserted at once. Power stays on until a second programmed tick count has elapsed, and is removed only then.

A loss of power-good while the slot is out of reset is a power fault. On a fault the block returns the slot to reset, cuts power in the same step and sets a sticky fault flag. The flag is cleared by a one-cycle clear pulse, the usual write-one-to-clear strobe from the register block that owns it. Both delays count a single-cycle tick input, normally one pulse per millisecond. The power-good input is active low, and a configuration input can invert its polarity.

Top module: `slot_pwr_seq`

## Requirements
- R1: After reset the block is idle with slot_pwr_en_o = 0, slot_rst_n_o = 0 and fault_o = 0.
- R2: When pwr_req_i = 1 while idle, slot_pwr_en_o goes to 1 on the next clock. slot_rst_n_o stays 0.
- R3: While powering up, reset is released on the clock at which the (p2r_dly_i+1)-th tick has arrived with power good. A value of 0 releases reset at the first such tick. A cycle with power not good restarts the count.
- R4: Power is good when pg_n_i equals pg_invert_i: low-true when pg_invert_i = 0, high-true when pg_invert_i = 1.
- R5: When pwr_req_i falls while the slot is running, slot_rst_n_o goes to 0 on the next clock. slot_pwr_en_o goes to 0 only at the clock on which the (r2p_dly_i+1)-th tick of that sequence arrives.
- R6: If power is not good while the slot is running (out of reset), then on the next clock slot_rst_n_o = 0, slot_pwr_en_o = 0 and fault_o = 1.
- R7: fault_o holds until a cycle with fault_clr_i = 1, which clears it on the next clock. A fault detected in the same cycle as a clear wins, so the flag stays 1.
- R8: After a fault the slot stays unpowered while pwr_req_i remains 1. Once pwr_req_i is 0 the block returns to idle, and a later request starts a normal power-up.
- R9: A power request that is raised again during a power-down sequence has no effect until that sequence ends. The block then starts a fresh power-up.
- R10: Dropping pwr_req_i during the power-up wait removes slot power on the next clock, with reset still asserted.
- R11: Loss of power-good while the slot reset is asserted (power-up wait or power-down) does not set fault_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle timebase pulse that the delays count |
| pwr_req_i | input | 1 | Software slot power request, 1 = power on |
| pg_n_i | input | 1 | Slot power-good input, active low by default |
| pg_invert_i | input | 1 | 1 inverts the polarity of pg_n_i |
| p2r_dly_i | input | DLY_W | Power-good-to-reset-release delay in ticks |
| r2p_dly_i | input | DLY_W | Reset-to-power-removal delay in ticks |
| fault_clr_i | input | 1 | One-cycle clear strobe for the fault flag |
| slot_pwr_en_o | output | 1 | Slot power enable |
| slot_rst_n_o | output | 1 | Active-low slot reset |
| fault_o | output | 1 | Sticky power-fault flag |

## Verification
Two functions can fall in the same cycle: detection of a power fault and the software clear of the fault flag. The bench drives power-good bad and fault_clr_i high on the same clock while the slot is running. It then expects fault_o to remain set, because the set must win over the clear. A second overlap is a new power request arriving inside a running power-down sequence. Here the bench expects power and reset to follow the power-down sequence to its end, and only then a fresh power-up. A behavioural model compares all three outputs on every clock across directed steps and a random phase.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [2:0] {
    S_OFF   = 3'd0,
    S_PWAIT = 3'd1,
    S_ON    = 3'd2,
    S_RBO   = 3'd3,
    S_FAULT = 3'd4
  } slot_st_e;

  // power-good decode: the line is good when it equals the polarity select
  function automatic logic pg_is_good(input logic pg_n, input logic inv);
    return (pg_n == inv);
  endfunction

  // a delay of D ticks completes when the count has reached D
  function automatic logic delay_reached(input logic [15:0] cnt, input logic [15:0] lim);
    return (cnt >= lim);
  endfunction

endpackage

// File: rtl/slot_pg_decode.sv
module slot_pg_decode (
  input  logic pg_n_i,
  input  logic pg_invert_i,
  output logic pg_ok_o
);
  import slot_seq_pkg::*;

  always_comb pg_ok_o = pg_is_good(pg_n_i, pg_invert_i);

endmodule

// File: rtl/slot_dly_timer.sv
module slot_dly_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  import slot_seq_pkg::*;

  localparam int PADW = 16 - W;

  logic [W-1:0] cnt_q;

  always_comb
    hit_o = run_i && tick_i &&
            delay_reached({{PADW{1'b0}}, cnt_q}, {{PADW{1'b0}}, limit_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || hit_o)  cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_req_i,
  input  logic                   pg_ok_i,
  input  logic                   hit_i,
  output slot_seq_pkg::slot_st_e state_o,
  output logic                   timer_run_o,
  output logic                   fault_evt_o
);
  import slot_seq_pkg::*;

  slot_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_OFF:   if (pwr_req_i) state_d = S_PWAIT;
      S_PWAIT: begin
        if (!pwr_req_i)  state_d = S_OFF;
        else if (hit_i)  state_d = S_ON;
      end
      S_ON: begin
        if (!pg_ok_i)        state_d = S_FAULT;
        else if (!pwr_req_i) state_d = S_RBO;
      end
      S_RBO:   if (hit_i) state_d = S_OFF;
      S_FAULT: if (!pwr_req_i) state_d = S_OFF;
      default: state_d = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_OFF;
    else        state_q <= state_d;
  end

  always_comb begin
    state_o     = state_q;
    timer_run_o = ((state_q == S_PWAIT) && pg_ok_i && pwr_req_i) || (state_q == S_RBO);
    fault_evt_o = (state_q == S_ON) && !pg_ok_i;
  end

endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pwr_req_i,
  input  logic             pg_n_i,
  input  logic             pg_invert_i,
  input  logic [DLY_W-1:0] p2r_dly_i,
  input  logic [DLY_W-1:0] r2p_dly_i,
  input  logic             fault_clr_i,
  output logic             slot_pwr_en_o,
  output logic             slot_rst_n_o,
  output logic             fault_o
);
  import slot_seq_pkg::*;

  logic             pg_ok;
  logic             timer_run;
  logic             timer_hit;
  logic             fault_evt;
  logic [DLY_W-1:0] active_lim;
  slot_st_e         state_q;
  logic             fault_q;

  slot_pg_decode u_pg (
    .pg_n_i      (pg_n_i),
    .pg_invert_i (pg_invert_i),
    .pg_ok_o     (pg_ok)
  );

  slot_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_req_i   (pwr_req_i),
    .pg_ok_i     (pg_ok),
    .hit_i       (timer_hit),
    .state_o     (state_q),
    .timer_run_o (timer_run),
    .fault_evt_o (fault_evt)
  );

  always_comb active_lim = (state_q == S_RBO) ? r2p_dly_i : p2r_dly_i;

  slot_dly_timer #(.W(DLY_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (timer_run),
    .tick_i  (tick_i),
    .limit_i (active_lim),
    .hit_o   (timer_hit)
  );

  // sticky fault flag: a new fault takes precedence over a clear strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fault_q <= 1'b0;
    else if (fault_evt)   fault_q <= 1'b1;
    else if (fault_clr_i) fault_q <= 1'b0;
  end

  always_comb begin
    slot_pwr_en_o = (state_q == S_PWAIT) || (state_q == S_ON) || (state_q == S_RBO);
    slot_rst_n_o  = (state_q == S_ON);
    fault_o       = fault_q;
  end

endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_i,
  input logic                   pwr_req_i,
  input logic                   pg_n_i,
  input logic                   pg_invert_i,
  input logic                   fault_clr_i,
  input logic                   slot_pwr_en_o,
  input logic                   slot_rst_n_o,
  input logic                   fault_o,
  input slot_seq_pkg::slot_st_e state_q,
  input logic                   fault_evt
);
  import slot_seq_pkg::*;

  // R2: the slot is never out of reset without power
  p_rst_when_unpowered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_pwr_en_o |-> !slot_rst_n_o);

  // R3: reset release happens only on a tick
  p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_rst_n_o) |-> $past(tick_i));

  // R4: reset release happens only with power good under the selected polarity
  p_release_pg_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_rst_n_o) |-> $past(pg_n_i == pg_invert_i));

  // R5: power is removed only after reset was already asserted, or by a fault
  p_reset_before_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slot_pwr_en_o) |-> ($past(!slot_rst_n_o) || $past(fault_evt)));

  // R6: a fault forces reset and power off and sets the flag
  p_fault_shutdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (fault_o && !slot_pwr_en_o && !slot_rst_n_o));

  // R7: the flag holds without a clear
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !fault_clr_i) |=> fault_o);

  // R7: a clear without a new fault clears the flag
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr_i && !fault_evt) |=> !fault_o);

  // R8: in fault with the request still high, the slot stays unpowered
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_FAULT) && pwr_req_i) |=> !slot_pwr_en_o);

  // R10: dropping the request during the wait removes power
  p_abort_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_PWAIT) && !pwr_req_i) |=> !slot_pwr_en_o);

endmodule

bind slot_pwr_seq slot_pwr_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .pwr_req_i     (pwr_req_i),
  .pg_n_i        (pg_n_i),
  .pg_invert_i   (pg_invert_i),
  .fault_clr_i   (fault_clr_i),
  .slot_pwr_en_o (slot_pwr_en_o),
  .slot_rst_n_o  (slot_rst_n_o),
  .fault_o       (fault_o),
  .state_q       (state_q),
  .fault_evt     (fault_evt)
);

// File: tb/test_slot_pwr_seq.sv
module test_slot_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b0;
  logic          pwr_req_i = 1'b0;
  logic          pg_n_i = 1'b1;
  logic          pg_invert_i = 1'b0;
  logic [DW-1:0] p2r_dly_i = 8'd3;
  logic [DW-1:0] r2p_dly_i = 8'd2;
  logic          fault_clr_i = 1'b0;
  logic          slot_pwr_en_o, slot_rst_n_o, fault_o;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  bit    compare_on = 1'b0;
  string cur_req = "R1";

  // behavioural model: phase 0 idle, 1 waiting, 2 running, 3 shutting down, 4 faulted
  int m_phase = 0;
  int m_ticks = 0;
  bit m_flag  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_pwr_seq #(.DLY_W(DW)) i_slot_pwr_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .pwr_req_i     (pwr_req_i),
    .pg_n_i        (pg_n_i),
    .pg_invert_i   (pg_invert_i),
    .p2r_dly_i     (p2r_dly_i),
    .r2p_dly_i     (r2p_dly_i),
    .fault_clr_i   (fault_clr_i),
    .slot_pwr_en_o (slot_pwr_en_o),
    .slot_rst_n_o  (slot_rst_n_o),
    .fault_o       (fault_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_ticks = 0; m_flag = 1'b0;
    end else begin
      bit good;
      bit faulted;
      int ph;
      good    = (pg_n_i == pg_invert_i);
      faulted = 1'b0;
      ph      = m_phase;
      if (ph == 0) begin
        if (pwr_req_i) begin m_phase = 1; m_ticks = 0; end
      end else if (ph == 1) begin
        if (!pwr_req_i)   begin m_phase = 0; m_ticks = 0; end
        else if (!good)   m_ticks = 0;
        else if (tick_i) begin
          if (m_ticks >= int'(p2r_dly_i)) begin m_phase = 2; m_ticks = 0; end
          else m_ticks++;
        end
      end else if (ph == 2) begin
        if (!good)           begin m_phase = 4; faulted = 1'b1; end
        else if (!pwr_req_i) begin m_phase = 3; m_ticks = 0; end
      end else if (ph == 3) begin
        if (tick_i) begin
          if (m_ticks >= int'(r2p_dly_i)) begin m_phase = 0; m_ticks = 0; end
          else m_ticks++;
        end
      end else begin
        if (!pwr_req_i) m_phase = 0;
      end
      if (faulted)          m_flag = 1'b1;
      else if (fault_clr_i) m_flag = 1'b0;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && !finished) begin
      check(cur_req, "model pwr_en", slot_pwr_en_o, (m_phase >= 1 && m_phase <= 3));
      check(cur_req, "model rst_n",  slot_rst_n_o,  (m_phase == 2));
      check(cur_req, "model fault",  fault_o,       m_flag);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      cycles(2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cycles(2);
    check("R1", "reset pwr_en", slot_pwr_en_o, 1'b0);
    check("R1", "reset rst_n",  slot_rst_n_o,  1'b0);
    check("R1", "reset fault",  fault_o,       1'b0);
    rst_n = 1'b1;
    compare_on = 1'b1;
    cycles(2);
    check("R1", "idle pwr_en", slot_pwr_en_o, 1'b0);

    // R2/R3: power-up with power-good initially bad
    cur_req = "R2";
    pwr_req_i = 1'b1;
    cycles(1);
    check("R2", "pwr_en after request", slot_pwr_en_o, 1'b1);
    check("R2", "rst_n held", slot_rst_n_o, 1'b0);
    cur_req = "R3";
    pulse_tick(5);
    check("R3", "no release without pg", slot_rst_n_o, 1'b0);
    pg_n_i = 1'b0;
    pulse_tick(2);
    pg_n_i = 1'b1;
    cycles(1);
    pg_n_i = 1'b0;
    pulse_tick(3);
    check("R3", "count restarted after pg drop", slot_rst_n_o, 1'b0);
    pulse_tick(1);
    check("R3", "release after p2r+1 ticks", slot_rst_n_o, 1'b1);

    // R5: power-down ordering
    cur_req = "R5";
    pwr_req_i = 1'b0;
    cycles(1);
    check("R5", "reset asserted first", slot_rst_n_o, 1'b0);
    check("R5", "power still on", slot_pwr_en_o, 1'b1);
    pulse_tick(2);
    check("R5", "power held during r2p", slot_pwr_en_o, 1'b1);
    pulse_tick(1);
    check("R5", "power removed", slot_pwr_en_o, 1'b0);

    // R4: inverted polarity, zero delay
    cur_req = "R4";
    pg_invert_i = 1'b1; pg_n_i = 1'b1; p2r_dly_i = 8'd0;
    pwr_req_i = 1'b1;
    cycles(1);
    pulse_tick(1);
    check("R4", "release with inverted pg high", slot_rst_n_o, 1'b1);

    // R6/R8/R7: fault handling
    cur_req = "R6";
    pg_n_i = 1'b0;
    cycles(1);
    check("R6", "fault flag", fault_o, 1'b1);
    check("R6", "fault pwr_en", slot_pwr_en_o, 1'b0);
    check("R6", "fault rst_n", slot_rst_n_o, 1'b0);
    cur_req = "R8";
    cycles(5);
    check("R8", "stay unpowered with request", slot_pwr_en_o, 1'b0);
    cur_req = "R7";
    cycles(3);
    check("R7", "flag sticky", fault_o, 1'b1);
    fault_clr_i = 1'b1;
    cycles(1);
    fault_clr_i = 1'b0;
    check("R7", "flag cleared", fault_o, 1'b0);
    cur_req = "R8";
    pg_n_i = 1'b1; pwr_req_i = 1'b0;
    cycles(1);
    pwr_req_i = 1'b1;
    cycles(1);
    check("R8", "repower after fault", slot_pwr_en_o, 1'b1);
    pulse_tick(1);
    check("R8", "running again", slot_rst_n_o, 1'b1);

    // R7: fault and clear in the same cycle
    cur_req = "R7";
    fault_clr_i = 1'b1; pg_n_i = 1'b0;
    cycles(1);
    fault_clr_i = 1'b0;
    check("R7", "set wins over clear", fault_o, 1'b1);
    pwr_req_i = 1'b0;
    cycles(2);
    fault_clr_i = 1'b1;
    cycles(1);
    fault_clr_i = 1'b0;
    pg_n_i = 1'b1;
    cycles(1);
    check("R7", "flag cleared later", fault_o, 1'b0);

    // R9: request raised during power-down
    cur_req = "R9";
    r2p_dly_i = 8'd4; p2r_dly_i = 8'd1;
    pwr_req_i = 1'b1;
    cycles(1);
    pulse_tick(2);
    check("R9", "running before off", slot_rst_n_o, 1'b1);
    pwr_req_i = 1'b0;
    cycles(1);
    pulse_tick(1);
    pwr_req_i = 1'b1;
    cycles(3);
    check("R9", "off sequence continues pwr", slot_pwr_en_o, 1'b1);
    check("R9", "off sequence continues rst", slot_rst_n_o, 1'b0);
    pulse_tick(4);
    check("R9", "fresh power-up pwr", slot_pwr_en_o, 1'b1);
    check("R9", "fresh power-up in reset", slot_rst_n_o, 1'b0);
    pulse_tick(2);
    check("R9", "fresh power-up released", slot_rst_n_o, 1'b1);

    // R10: abort during wait
    cur_req = "R10";
    pwr_req_i = 1'b0;
    cycles(1);
    pulse_tick(5);
    pwr_req_i = 1'b1;
    cycles(1);
    pwr_req_i = 1'b0;
    cycles(1);
    check("R10", "abort removes power", slot_pwr_en_o, 1'b0);

    // R11: pg loss while in reset
    cur_req = "R11";
    pwr_req_i = 1'b1;
    cycles(1);
    pulse_tick(2);
    pwr_req_i = 1'b0;
    cycles(1);
    pg_n_i = 1'b0;
    pulse_tick(5);
    check("R11", "no fault in off sequence", fault_o, 1'b0);
    check("R11", "off reached", slot_pwr_en_o, 1'b0);
    pwr_req_i = 1'b1;
    pulse_tick(3);
    check("R11", "no fault in wait", fault_o, 1'b0);
    pg_n_i = 1'b1;

    // random phase against the model
    cur_req = "R6";
    p2r_dly_i = 8'd2; r2p_dly_i = 8'd1;
    for (int c = 0; c < 3000; c++) begin
      tick_i      = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 40) == 0) pwr_req_i = ~pwr_req_i;
      pg_n_i      = ($urandom_range(0, 30) == 0) ? ~pg_invert_i : pg_invert_i;
      fault_clr_i = ($urandom_range(0, 20) == 0);
      if ($urandom_range(0, 500) == 0) pg_invert_i = ~pg_invert_i;
      @(negedge clk);
    end
    tick_i = 1'b0; fault_clr_i = 1'b0;
    cycles(2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule